// File: doc/BRIEF.md
# Single-Button Stopwatch with Multiplexed Seven-Segment Display

This block times sports events to whole-second resolution. One push-button
controls it. Each accepted press moves it one step around a loop of three
modes: cleared, running and held. A press in the cleared mode starts the count.
A press while running freezes the count. A press in the held mode returns the
count to zero. Time is kept as three BCD digits (minutes, tens of seconds, ones
of seconds), so the longest time shown is 9:59.

The raw button is brought into the clock domain and debounced. Only a clean
rising level counts as a press. A prescaler turns the board clock into one
pulse per second, and that pulse advances the count only while running. The
time is shown on a row of common-cathode seven-segment digits, lit one at a
time by a walking one-hot select. The three rightmost positions carry M, S and
S. The positions to their left are dark.

Top module: `sw_stopwatch`

## Requirements
- R1: After the synchronous active-high reset the block is in the cleared mode, shows 0:00 on the three rightmost positions with the other positions blank, and does not count.
- R2: A press in the cleared mode starts counting. The first increment comes one prescaler period after the press is accepted.
- R3: A press while running stops the count. The time shown then stays frozen for as long as no further press arrives.
- R4: A press in the held mode returns the display to 0:00. The block then stays at 0:00 until the next press.
- R5: The seconds run 00 to 59 in BCD. The step after x:59 gives (x+1):00.
- R6: When running reaches 9:59, the count holds at 9:59 and does not wrap.
- R7: A button level that changes for fewer than DEBOUNCE_CYCLES consecutive clocks has no effect. A press is counted once on the debounced rising level, however long it is held, and release does nothing.
- R8: `digit_sel` always has exactly one bit set. The set bit starts at the MSB, steps one place toward the LSB every SCAN_CYCLES clocks, and wraps from the LSB back to the MSB.
- R9: The segment bus is active high with bit 0 = a through bit 6 = g. The digits 0..9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F, and a blank position is 0x00.
- R10: While running, the time advances by exactly one second every TICK_CYCLES clocks. A run of k periods plus half a period therefore shows k seconds, saturated at 9:59.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (1 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| btn | input | 1 | Raw push-button level, asynchronous, high when pressed |
| digit_sel | output | NUM_DIGITS | One-hot digit enable; MSB is the leftmost digit |
| seg | output | 7 | Segments a..g in bits 0..6, active high |

## Verification
The bench builds the block with DEBOUNCE_CYCLES = 4, TICK_CYCLES = 20 and SCAN_CYCLES = 3. With these values the 600-second run to the 9:59 ceiling fits in about twelve thousand clocks, and a full display scan fits in eighteen. Because the short debounce window is only four clocks, a two-clock glitch, a long hold and a clean press can all be placed at exact cycle offsets. This makes every elapsed time an exact multiple of the tick period, so each displayed value can be predicted exactly.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_HOLD  = 2'd2
    } sw_mode_e;

    typedef struct packed {
        logic [3:0] mins;
        logic [3:0] tens;
        logic [3:0] ones;
    } sw_time_t;

    localparam int       SEG_W     = 7;
    localparam sw_time_t TIME_ZERO = '{mins: 4'd0, tens: 4'd0, ones: 4'd0};
    localparam sw_time_t TIME_MAX  = '{mins: 4'd9, tens: 4'd5, ones: 4'd9};
    localparam logic [SEG_W-1:0] SEG_BLANK = '0;

    // One-second step in BCD, holding at the ceiling.
    function automatic sw_time_t time_step(sw_time_t t);
        sw_time_t n;
        n = t;
        if (t == TIME_MAX) begin
            n = t;
        end else if (t.ones != 4'd9) begin
            n.ones = t.ones + 4'd1;
        end else if (t.tens != 4'd5) begin
            n.ones = 4'd0;
            n.tens = t.tens + 4'd1;
        end else begin
            n.ones = 4'd0;
            n.tens = 4'd0;
            n.mins = t.mins + 4'd1;
        end
        return n;
    endfunction

    function automatic sw_mode_e mode_after_press(sw_mode_e m);
        case (m)
            MODE_CLEAR: return MODE_RUN;
            MODE_RUN:   return MODE_HOLD;
            default:    return MODE_CLEAR;
        endcase
    endfunction

    // Segment bit 0 = a ... bit 6 = g, high lights the segment.
    function automatic logic [SEG_W-1:0] seg_of(logic [3:0] d);
        case (d)
            4'd0:    return 7'h3F;
            4'd1:    return 7'h06;
            4'd2:    return 7'h5B;
            4'd3:    return 7'h4F;
            4'd4:    return 7'h66;
            4'd5:    return 7'h6D;
            4'd6:    return 7'h7D;
            4'd7:    return 7'h07;
            4'd8:    return 7'h7F;
            4'd9:    return 7'h6F;
            default: return SEG_BLANK;
        endcase
    endfunction

endpackage

// File: rtl/sw_debounce.sv
module sw_debounce #(
    parameter int STABLE_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES - 1);

    logic          sync_a, sync_b;
    logic          level;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            level  <= 1'b0;
            cnt    <= '0;
            press  <= 1'b0;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
            press  <= 1'b0;
            if (sync_b == level) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                cnt   <= '0;
                level <= sync_b;
                press <= sync_b;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);
    p_press_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
        press |-> (level && !$past(level)));

endmodule

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
    parameter int PERIOD = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CNT_LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    generate
        if (PERIOD > 1) begin : g_gap
            p_tick_gap_r10: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/sw_timer_core.sv
module sw_timer_core
    import sw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     press,
    input  logic     tick,
    output sw_mode_e mode,
    output sw_time_t now
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_CLEAR;
            now  <= TIME_ZERO;
        end else if (press) begin
            mode <= mode_after_press(mode);
            if (mode == MODE_HOLD) begin
                now <= TIME_ZERO;
            end
        end else if (mode == MODE_RUN && tick) begin
            now <= time_step(now);
        end
    end

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (press && mode == MODE_CLEAR) |=> mode == MODE_RUN);
    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD && !press) |=> $stable(now));
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLEAR) |-> now == TIME_ZERO);
    p_bcd_range_r5: assert property (@(posedge clk) disable iff (rst)
        now.ones <= 4'd9 && now.tens <= 4'd5 && now.mins <= 4'd9);
    p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && now == TIME_MAX && !press) |=> now == TIME_MAX);

endmodule

// File: rtl/sw_scan.sv
module sw_scan
    import sw_pkg::*;
#(
    parameter int NUM_DIGITS = 6,
    parameter int DWELL      = 1000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sw_time_t              now,
    output logic [NUM_DIGITS-1:0] digit_sel,
    output logic [SEG_W-1:0]      seg
);
    localparam int IW = $clog2(NUM_DIGITS);
    localparam int DW = $clog2(DWELL + 1);
    localparam logic [IW-1:0] IDX_LAST   = IW'(NUM_DIGITS - 1);
    localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL - 1);

    logic [IW-1:0]    idx;
    logic [DW-1:0]    dwell;
    logic [SEG_W-1:0] pos_seg [NUM_DIGITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            dwell <= '0;
        end else if (dwell == DWELL_LAST) begin
            dwell <= '0;
            idx   <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
        end else begin
            dwell <= dwell + 1'b1;
        end
    end

    // Rightmost three positions carry M, S, S; the rest stay dark.
    generate
        for (genvar p = 0; p < NUM_DIGITS; p++) begin : g_pos
            if (p == NUM_DIGITS - 3) begin : g_min
                assign pos_seg[p] = seg_of(now.mins);
            end else if (p == NUM_DIGITS - 2) begin : g_tens
                assign pos_seg[p] = seg_of(now.tens);
            end else if (p == NUM_DIGITS - 1) begin : g_ones
                assign pos_seg[p] = seg_of(now.ones);
            end else begin : g_blank
                assign pos_seg[p] = SEG_BLANK;
            end
        end
    endgenerate

    always_comb begin
        digit_sel = '0;
        digit_sel[IW'(NUM_DIGITS - 1) - idx] = 1'b1;
        seg = pos_seg[idx];
    end

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(digit_sel) == 1);
    p_dwell_r8: assert property (@(posedge clk) disable iff (rst)
        (dwell != DWELL_LAST) |=> $stable(digit_sel));

endmodule

// File: rtl/sw_stopwatch.sv
module sw_stopwatch
    import sw_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 20000,
    parameter int TICK_CYCLES     = 1000000,
    parameter int SCAN_CYCLES     = 1000,
    parameter int NUM_DIGITS      = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  btn,
    output logic [NUM_DIGITS-1:0] digit_sel,
    output logic [6:0]            seg
);
    logic     press;
    logic     tick;
    sw_mode_e mode;
    sw_time_t now;

    sw_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) i_debounce (
        .clk   (clk),
        .rst   (rst),
        .raw   (btn),
        .press (press)
    );

    sw_tick_gen #(.PERIOD(TICK_CYCLES)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode != MODE_RUN),
        .tick (tick)
    );

    sw_timer_core i_core (
        .clk   (clk),
        .rst   (rst),
        .press (press),
        .tick  (tick),
        .mode  (mode),
        .now   (now)
    );

    sw_scan #(.NUM_DIGITS(NUM_DIGITS), .DWELL(SCAN_CYCLES)) i_scan (
        .clk       (clk),
        .rst       (rst),
        .now       (now),
        .digit_sel (digit_sel),
        .seg       (seg)
    );

endmodule

// File: tb/test_sw_stopwatch.sv
module test_sw_stopwatch;
    localparam int CLK_PERIOD = 10;
    localparam int DB   = 4;
    localparam int TICK = 20;
    localparam int SCAN = 3;
    localparam int ND   = 6;
    localparam int PRESS_LEN = 4 * DB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          btn = 1'b0;
    logic [ND-1:0] digit_sel;
    logic [6:0]    seg;

    int checks = 0;
    int errors = 0;
    int disp [ND];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_stopwatch #(.DEBOUNCE_CYCLES(DB), .TICK_CYCLES(TICK),
                   .SCAN_CYCLES(SCAN), .NUM_DIGITS(ND)) i_sw_stopwatch (
        .clk(clk), .rst(rst), .btn(btn), .digit_sel(digit_sel), .seg(seg));

    // Decoding per R9: 0..9 digits, 14 blank, 15 unknown pattern.
    function automatic int seg_to_digit(logic [6:0] s);
        case (s)
            7'h3F: return 0;  7'h06: return 1;  7'h5B: return 2;
            7'h4F: return 3;  7'h66: return 4;  7'h6D: return 5;
            7'h7D: return 6;  7'h07: return 7;  7'h7F: return 8;
            7'h6F: return 9;  7'h00: return 14;
            default: return 15;
        endcase
    endfunction

    function automatic int expect_code(int secs);
        int s;
        s = (secs > 599) ? 599 : secs;
        return (s / 60) * 100 + ((s % 60) / 10) * 10 + (s % 10);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_btn();
        btn = 1'b1;
        wait_cycles(2 * DB);
        btn = 1'b0;
        wait_cycles(2 * DB);
    endtask

    task automatic read_display();
        for (int i = 0; i < ND; i++) disp[i] = 15;
        for (int c = 0; c < ND * SCAN + 2; c++) begin
            @(negedge clk);
            for (int p = 0; p < ND; p++)
                if (digit_sel == ND'(1) << (ND - 1 - p)) disp[p] = seg_to_digit(seg);
        end
    endtask

    function automatic int shown_code();
        return disp[ND-3] * 100 + disp[ND-2] * 10 + disp[ND-1];
    endfunction

    task automatic check_display(int secs, string req, string what);
        int blanks;
        read_display();
        blanks = 0;
        for (int p = 0; p < ND - 3; p++) if (disp[p] == 14) blanks++;
        check(shown_code() == expect_code(secs), req, what, shown_code(), expect_code(secs));
        check(blanks == ND - 3, "R9", {what, " blank positions"}, blanks, ND - 3);
    endtask

    // Start from cleared, run k periods plus half, stop, verify, then clear.
    task automatic timed_run(int k, string req);
        press_btn();
        wait_cycles(k * TICK + TICK / 2 - PRESS_LEN);
        press_btn();
        check_display(k, req, "held time after run");
        wait_cycles(3 * TICK);
        check_display(k, "R3", "held time stays frozen");
        press_btn();
        check_display(0, "R4", "cleared after third press");
    endtask

    task automatic scan_walk_check();
        logic [ND-1:0] prev;
        int run_len, bad_hot, bad_step, bad_len, steps;
        bad_hot = 0; bad_step = 0; bad_len = 0; steps = 0;
        @(negedge clk);
        prev = digit_sel;
        run_len = -1000;
        for (int c = 0; c < 8 * ND * SCAN; c++) begin
            @(negedge clk);
            if ($countones(digit_sel) != 1) bad_hot++;
            if (digit_sel == prev) begin
                run_len++;
            end else begin
                if (!(digit_sel == (prev >> 1) || (prev == ND'(1) && digit_sel == ND'(1) << (ND-1))))
                    bad_step++;
                if (run_len > 0 && run_len != SCAN) bad_len++;
                steps++;
                run_len = 1;
            end
            prev = digit_sel;
        end
        check(bad_hot == 0, "R8", "one-hot select", bad_hot, 0);
        check(bad_step == 0, "R8", "walk order MSB to LSB with wrap", bad_step, 0);
        check(bad_len == 0, "R8", "dwell per position", bad_len, 0);
        check(steps >= 7 * ND, "R8", "scan keeps moving", steps, 7 * ND);
    endtask

    initial begin
        int first, second;
        void'($urandom(32'd2024));
        wait_cycles(5);
        rst = 1'b0;

        // R1: reset state and no counting without a press.
        check_display(0, "R1", "display after reset");
        wait_cycles(4 * TICK);
        check_display(0, "R1", "no counting before a press");

        scan_walk_check();

        // R2 / R10 / R5: directed lengths around the seconds rollover.
        timed_run(1, "R2");
        timed_run(59, "R5");
        timed_run(60, "R5");
        timed_run(119, "R10");
        timed_run(598, "R6");
        timed_run(599, "R6");
        timed_run(620, "R6");

        // R7: glitch while cleared is ignored.
        btn = 1'b1; wait_cycles(DB - 2); btn = 1'b0;
        wait_cycles(5 * TICK);
        check_display(0, "R7", "short glitch in cleared mode");

        // R7: glitch while running does not stop the count.
        press_btn();
        wait_cycles(3 * TICK);
        btn = 1'b1; wait_cycles(DB - 2); btn = 1'b0;
        wait_cycles(12 * TICK + TICK / 2 - PRESS_LEN - 3 * TICK - (DB - 2));
        press_btn();
        check_display(12, "R7", "glitch while running ignored");
        press_btn();

        // R7: a long hold is one press; release does nothing.
        btn = 1'b1; wait_cycles(10 * TICK); btn = 1'b0;
        wait_cycles(2 * DB);
        wait_cycles(15 * TICK + TICK / 2 - 10 * TICK - 2 * DB);
        press_btn();
        check_display(15, "R7", "long hold counted once");
        press_btn();

        // R2: counting visibly advances while running.
        press_btn();
        wait_cycles(2 * TICK);
        read_display(); first = shown_code();
        wait_cycles(3 * TICK);
        read_display(); second = shown_code();
        check(second > first, "R2", "time advances while running", second, first + 3);
        press_btn();
        press_btn();

        // R10: random run lengths.
        for (int n = 0; n < 6; n++) begin
            int k;
            k = $urandom_range(1, 150);
            timed_run(k, "R10");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule